// File: doc/BRIEF.md
# Paired-Page Translation Buffer

A small, fully associative address translation buffer of the software-refilled kind. Each slot holds one virtual tag that covers two adjacent 4 KB pages. The even and odd page each have their own physical frame, valid bit, dirty bit and 3-bit cache attribute. Software fills slots through staging registers: an upper word with the tag and address-space ID, and two lower words, one for each page. It then issues one of four operations: write the slot named by the index register, write the slot named by a free-running replacement counter, read the indexed slot back into the staging registers, or probe for the staged tag.

The translation port is combinational. It takes a virtual address, a write flag and the current address-space ID. It returns the physical address, read and write permissions and a two-bit fault code. The fault code separates a missing mapping, an invalid page and a write to a clean page. A slot marked global matches under any address-space ID. All operations take effect at the next rising clock edge.

Top module: `pairtlb`

## Requirements
- R1: An indexed write (op code 0 on `op_kind` with `op_go` high) copies the staging registers into slot `index_q & (ENTRIES-1)` at the next clock edge. Index bits above the slot field are ignored.
- R2: A replacement write (op code 1) stores into the slot given by the value of `random_q` at that clock edge.
- R3: The stored global flag is the AND of bit 0 of both lower staging words. A slot matches when its tag equals address bits 31:13 and either the slot is global or its ID equals the ID being compared. When several slots match, the lowest-numbered slot is used.
- R4: When no slot matches, `fault` is 1 (miss).
- R5: Address bit 12 selects the half of the matching slot: 0 is the even page, 1 is the odd page. If the selected half is not valid, `fault` is 2 (invalid), for reads and writes alike.
- R6: A write to a valid half whose dirty bit is clear gives `fault` 3 (modified). A read of the same half succeeds.
- R7: On success, `fault` is 0, `pa` is the half's frame number shifted left by 12 ORed with address bits 11:0, `perm_rd` is 1, and `perm_wr` equals the half's dirty bit. On any fault, both permission bits are 0.
- R8: A read-back (op code 2) loads the upper staging word with tag<<13 | ID, with bits 12:8 zero. It loads each lower word with global | valid<<1 | dirty<<2 | attribute<<3 | frame<<6, with bits 31:26 zero. The global flag appears in both lower words.
- R9: A probe (op code 3) compares the tag and ID from the upper staging word under the rule of R3. On a hit it writes the matching slot number into the index register, with bit 31 clear. On a miss it writes 0x8000_0000.
- R10: `random_q` resets to 15 and moves each clock. If its value is at or below the lower bound in `wired_q`, the next value is 15. Otherwise it decreases by one.
- R11: Reset clears all staging registers, the index register, the lower bound and every slot field. Right after reset, a lookup with tag 0 and ID 0 therefore returns the invalid fault.
- R12: `stg_sel` selects which register a staging write loads: 0 upper word, 1 even lower word, 2 odd lower word, 3 index, 4 lower bound. A staging write is dropped when `op_go` is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stg_we | input | 1 | Staging register write strobe |
| stg_sel | input | 3 | Staging register select |
| stg_wdata | input | 32 | Staging write data |
| op_go | input | 1 | Issue an operation this cycle |
| op_kind | input | 2 | Operation: 0 indexed write, 1 replacement write, 2 read-back, 3 probe |
| va | input | 32 | Virtual address to translate |
| va_is_write | input | 1 | Access is a write |
| cur_asid | input | 8 | Current address-space ID |
| pa | output | 32 | Physical address |
| perm_rd | output | 1 | Access readable |
| perm_wr | output | 1 | Access writable |
| fault | output | 2 | 0 none, 1 miss, 2 invalid, 3 modified |
| hi_q | output | 32 | Upper staging word |
| lo0_q | output | 32 | Even-page lower staging word |
| lo1_q | output | 32 | Odd-page lower staging word |
| index_q | output | 32 | Index register |
| wired_q | output | 4 | Replacement lower bound |
| random_q | output | 4 | Replacement slot counter |

## Verification
The bench fills all sixteen slots with mixed valid, dirty and global patterns. It then sweeps every slot, both halves, reads and writes, and matched and foreign IDs. The sweep exposes a design that swaps halves, checks dirty before valid, or merges the invalid and modified faults. Read-back of every slot catches a global flag taken from only one word, or junk bits leaking into bits 12:8 or 31:26. A duplicate tag placed in a higher slot shows whether the lowest slot wins. An out-of-range index shows whether the slot field is masked. The replacement counter is traced over many cycles, with and without a lower bound, so an off-by-one wrap or a wrong reset value shows up at once.

// File: rtl/pairtlb_pkg.sv
`timescale 1ns/1ps
package pairtlb_pkg;
   typedef enum logic [1:0] {
      OP_WR_IDX = 2'd0,
      OP_WR_RND = 2'd1,
      OP_RD_IDX = 2'd2,
      OP_PROBE  = 2'd3
   } tlb_op_e;

   typedef enum logic [1:0] {
      FLT_NONE    = 2'd0,
      FLT_MISS    = 2'd1,
      FLT_INVALID = 2'd2,
      FLT_MOD     = 2'd3
   } tlb_fault_e;

   localparam logic [2:0] SEL_HI    = 3'd0;
   localparam logic [2:0] SEL_LO0   = 3'd1;
   localparam logic [2:0] SEL_LO1   = 3'd2;
   localparam logic [2:0] SEL_INDEX = 3'd3;
   localparam logic [2:0] SEL_WIRED = 3'd4;

   localparam int LO_G       = 0;
   localparam int LO_V       = 1;
   localparam int LO_D       = 2;
   localparam int LO_ATTR    = 3;
   localparam int ATTR_W     = 3;
   localparam int LO_PFN     = 6;
   localparam int PAGE_SHIFT = 12;
   localparam int PAIR_SHIFT = 13;
endpackage

// File: rtl/pairtlb_entry.sv
`timescale 1ns/1ps
module pairtlb_entry
   import pairtlb_pkg::*;
#(
   parameter  int VA_W   = 32,
   parameter  int ASID_W = 8,
   parameter  int PFN_W  = 20,
   parameter  int REG_W  = 32,
   localparam int TAG_W  = VA_W - PAIR_SHIFT
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [VA_W-1:0]              hi_in,
   input  logic [REG_W-1:0]             lo0_in,
   input  logic [REG_W-1:0]             lo1_in,
   input  logic [TAG_W-1:0]             xl_tag_i,
   input  logic [ASID_W-1:0]            xl_asid_i,
   input  logic [TAG_W-1:0]             pr_tag_i,
   input  logic [ASID_W-1:0]            pr_asid_i,
   output logic                         xl_hit_o,
   output logic                         pr_hit_o,
   output logic [TAG_W-1:0]             tag_o,
   output logic [ASID_W-1:0]            asid_o,
   output logic                         glob_o,
   output logic [1:0]                   vld_o,
   output logic [1:0]                   dty_o,
   output logic [1:0][ATTR_W-1:0]       attr_o,
   output logic [1:0][PFN_W-1:0]        pfn_o
);
   logic [1:0][REG_W-1:0] lo_in;
   assign lo_in = {lo1_in, lo0_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_o  <= '0;
         asid_o <= '0;
         glob_o <= 1'b0;
      end else if (wr_en) begin
         tag_o  <= hi_in[VA_W-1:PAIR_SHIFT];
         asid_o <= hi_in[ASID_W-1:0];
         glob_o <= lo0_in[LO_G] & lo1_in[LO_G];
      end
   end

   for (genvar h = 0; h < 2; h++) begin : g_half
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_o[h]  <= 1'b0;
            dty_o[h]  <= 1'b0;
            attr_o[h] <= '0;
            pfn_o[h]  <= '0;
         end else if (wr_en) begin
            vld_o[h]  <= lo_in[h][LO_V];
            dty_o[h]  <= lo_in[h][LO_D];
            attr_o[h] <= lo_in[h][LO_ATTR +: ATTR_W];
            pfn_o[h]  <= lo_in[h][LO_PFN +: PFN_W];
         end
      end
   end

   assign xl_hit_o = (tag_o == xl_tag_i) && (glob_o || (asid_o == xl_asid_i));
   assign pr_hit_o = (tag_o == pr_tag_i) && (glob_o || (asid_o == pr_asid_i));
endmodule

// File: rtl/pairtlb_prio.sv
`timescale 1ns/1ps
module pairtlb_prio #(
   parameter  int N  = 16,
   localparam int IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  hit_i,
   output logic          any_o,
   output logic [IW-1:0] idx_o
);
   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (hit_i[k]) begin
            any_o = 1'b1;
            idx_o = IW'(k);
         end
      end
   end

   // R3
   sel_is_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_o |-> hit_i[idx_o]);

   // R3
   sel_is_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_o |-> ((hit_i & ((N'(1) << idx_o) - N'(1))) == '0));
endmodule

// File: rtl/pairtlb_rand.sv
`timescale 1ns/1ps
module pairtlb_rand #(
   parameter  int N  = 16,
   localparam int IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] wired_i,
   output logic [IW-1:0] rand_o
);
   localparam logic [IW-1:0] TOP = IW'(N - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                rand_o <= TOP;
      else if (rand_o <= wired_i) rand_o <= TOP;
      else                        rand_o <= rand_o - 1'b1;
   end

   // R10
   rand_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rand_o > wired_i) |=> (rand_o == $past(rand_o) - 1'b1));
endmodule

// File: rtl/pairtlb.sv
`timescale 1ns/1ps
module pairtlb
   import pairtlb_pkg::*;
#(
   parameter  int ENTRIES = 16,
   parameter  int VA_W    = 32,
   parameter  int PA_W    = 32,
   parameter  int ASID_W  = 8,
   parameter  int REG_W   = 32,
   localparam int IDX_W   = $clog2(ENTRIES),
   localparam int TAG_W   = VA_W - PAIR_SHIFT,
   localparam int PFN_W   = PA_W - PAGE_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stg_we,
   input  logic [2:0]        stg_sel,
   input  logic [REG_W-1:0]  stg_wdata,
   input  logic              op_go,
   input  logic [1:0]        op_kind,
   input  logic [VA_W-1:0]   va,
   input  logic              va_is_write,
   input  logic [ASID_W-1:0] cur_asid,
   output logic [PA_W-1:0]   pa,
   output logic              perm_rd,
   output logic              perm_wr,
   output logic [1:0]        fault,
   output logic [VA_W-1:0]   hi_q,
   output logic [REG_W-1:0]  lo0_q,
   output logic [REG_W-1:0]  lo1_q,
   output logic [REG_W-1:0]  index_q,
   output logic [IDX_W-1:0]  wired_q,
   output logic [IDX_W-1:0]  random_q
);
   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("pairtlb: ENTRIES must be a power of two of at least 2");
   end
   if (ASID_W > PAIR_SHIFT) begin : g_bad_asid
      $error("pairtlb: ASID_W overlaps the tag field");
   end
   if (LO_PFN + PFN_W > REG_W || VA_W > REG_W) begin : g_bad_regw
      $error("pairtlb: staging word too narrow");
   end

   tlb_op_e op;
   assign op = tlb_op_e'(op_kind);

   logic [ENTRIES-1:0]       xl_hits, pr_hits, wr_vec, e_glob;
   logic [TAG_W-1:0]         e_tag  [ENTRIES];
   logic [ASID_W-1:0]        e_asid [ENTRIES];
   logic [1:0]               e_vld  [ENTRIES];
   logic [1:0]               e_dty  [ENTRIES];
   logic [1:0][ATTR_W-1:0]   e_attr [ENTRIES];
   logic [1:0][PFN_W-1:0]    e_pfn  [ENTRIES];

   logic             do_wr;
   logic [IDX_W-1:0] wr_slot, rd_idx, xl_idx, pr_idx;
   logic             xl_any, pr_any;

   assign do_wr   = op_go && (op == OP_WR_IDX || op == OP_WR_RND);
   assign wr_slot = (op == OP_WR_RND) ? random_q : index_q[IDX_W-1:0];
   assign rd_idx  = index_q[IDX_W-1:0];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      assign wr_vec[g] = do_wr && (wr_slot == IDX_W'(g));
      pairtlb_entry #(.VA_W(VA_W), .ASID_W(ASID_W), .PFN_W(PFN_W), .REG_W(REG_W)) u_ent (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (wr_vec[g]),
         .hi_in     (hi_q),
         .lo0_in    (lo0_q),
         .lo1_in    (lo1_q),
         .xl_tag_i  (va[VA_W-1:PAIR_SHIFT]),
         .xl_asid_i (cur_asid),
         .pr_tag_i  (hi_q[VA_W-1:PAIR_SHIFT]),
         .pr_asid_i (hi_q[ASID_W-1:0]),
         .xl_hit_o  (xl_hits[g]),
         .pr_hit_o  (pr_hits[g]),
         .tag_o     (e_tag[g]),
         .asid_o    (e_asid[g]),
         .glob_o    (e_glob[g]),
         .vld_o     (e_vld[g]),
         .dty_o     (e_dty[g]),
         .attr_o    (e_attr[g]),
         .pfn_o     (e_pfn[g])
      );
   end

   pairtlb_prio #(.N(ENTRIES)) u_xl_prio (
      .clk(clk), .rst_n(rst_n), .hit_i(xl_hits), .any_o(xl_any), .idx_o(xl_idx));
   pairtlb_prio #(.N(ENTRIES)) u_pr_prio (
      .clk(clk), .rst_n(rst_n), .hit_i(pr_hits), .any_o(pr_any), .idx_o(pr_idx));
   pairtlb_rand #(.N(ENTRIES)) u_rand (
      .clk(clk), .rst_n(rst_n), .wired_i(wired_q), .rand_o(random_q));

   // translation path
   logic             half, sel_vld, sel_dty;
   logic [PFN_W-1:0] sel_pfn;
   tlb_fault_e       flt;

   assign half    = va[PAGE_SHIFT];
   assign sel_vld = e_vld[xl_idx][half];
   assign sel_dty = e_dty[xl_idx][half];
   assign sel_pfn = e_pfn[xl_idx][half];

   always_comb begin
      if (!xl_any)                      flt = FLT_MISS;
      else if (!sel_vld)                flt = FLT_INVALID;
      else if (va_is_write && !sel_dty) flt = FLT_MOD;
      else                              flt = FLT_NONE;
   end

   assign fault   = flt;
   assign perm_rd = (flt == FLT_NONE);
   assign perm_wr = (flt == FLT_NONE) && sel_dty;
   assign pa      = {sel_pfn, va[PAGE_SHIFT-1:0]};

   // read-back words
   function automatic logic [REG_W-1:0] pack_lo(input logic g, input logic v, input logic d,
                                                input logic [ATTR_W-1:0] a,
                                                input logic [PFN_W-1:0] p);
      logic [REG_W-1:0] w;
      w = '0;
      w[LO_G]              = g;
      w[LO_V]              = v;
      w[LO_D]              = d;
      w[LO_ATTR +: ATTR_W] = a;
      w[LO_PFN +: PFN_W]   = p;
      return w;
   endfunction

   logic [VA_W-1:0]  rb_hi;
   logic [REG_W-1:0] rb_lo0, rb_lo1;

   always_comb begin
      rb_hi = '0;
      rb_hi[VA_W-1:PAIR_SHIFT] = e_tag[rd_idx];
      rb_hi[ASID_W-1:0]        = e_asid[rd_idx];
      rb_lo0 = pack_lo(e_glob[rd_idx], e_vld[rd_idx][0], e_dty[rd_idx][0],
                       e_attr[rd_idx][0], e_pfn[rd_idx][0]);
      rb_lo1 = pack_lo(e_glob[rd_idx], e_vld[rd_idx][1], e_dty[rd_idx][1],
                       e_attr[rd_idx][1], e_pfn[rd_idx][1]);
   end

   // staging registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q    <= '0;
         lo0_q   <= '0;
         lo1_q   <= '0;
         index_q <= '0;
         wired_q <= '0;
      end else if (op_go) begin
         case (op)
            OP_RD_IDX: begin
               hi_q  <= rb_hi;
               lo0_q <= rb_lo0;
               lo1_q <= rb_lo1;
            end
            OP_PROBE:  index_q <= pr_any ? REG_W'(pr_idx) : (REG_W'(1) << (REG_W - 1));
            default:   ;
         endcase
      end else if (stg_we) begin
         case (stg_sel)
            SEL_HI:    hi_q    <= stg_wdata[VA_W-1:0];
            SEL_LO0:   lo0_q   <= stg_wdata;
            SEL_LO1:   lo1_q   <= stg_wdata;
            SEL_INDEX: index_q <= stg_wdata;
            SEL_WIRED: wired_q <= stg_wdata[IDX_W-1:0];
            default:   ;
         endcase
      end
   end

   // R6
   mod_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault == 2'd3) |-> va_is_write);

   // R7
   wr_implies_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      perm_wr |-> perm_rd);

   // R9
   probe_miss_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_go && op == OP_PROBE && !pr_any) |=> (index_q[REG_W-1] && index_q[IDX_W-1:0] == '0));

   // R9
   probe_hit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_go && op == OP_PROBE && pr_any) |=> !index_q[REG_W-1]);
endmodule

// File: tb/pairtlb_bench.sv
`timescale 1ns/1ps
module pairtlb_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stg_we = 1'b0;
   logic [2:0]  stg_sel = '0;
   logic [31:0] stg_wdata = '0;
   logic        op_go = 1'b0;
   logic [1:0]  op_kind = '0;
   logic [31:0] va = '0;
   logic        va_is_write = 1'b0;
   logic [7:0]  cur_asid = '0;
   logic [31:0] pa;
   logic        perm_rd, perm_wr;
   logic [1:0]  fault;
   logic [31:0] hi_q, lo0_q, lo1_q, index_q;
   logic [3:0]  wired_q, random_q;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   pairtlb u_pairtlb (
      .clk(clk), .rst_n(rst_n), .stg_we(stg_we), .stg_sel(stg_sel), .stg_wdata(stg_wdata),
      .op_go(op_go), .op_kind(op_kind), .va(va), .va_is_write(va_is_write), .cur_asid(cur_asid),
      .pa(pa), .perm_rd(perm_rd), .perm_wr(perm_wr), .fault(fault),
      .hi_q(hi_q), .lo0_q(lo0_q), .lo1_q(lo1_q), .index_q(index_q),
      .wired_q(wired_q), .random_q(random_q));

   always #5 clk = ~clk;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic stage(input logic [2:0] s, input logic [31:0] d);
      @(negedge clk);
      stg_sel = s; stg_wdata = d; stg_we = 1'b1;
      @(negedge clk);
      stg_we = 1'b0;
   endtask

   task automatic do_op(input logic [1:0] k);
      @(negedge clk);
      op_kind = k; op_go = 1'b1;
      @(negedge clk);
      op_go = 1'b0;
   endtask

   task automatic xl(input logic [31:0] a, input logic w, input logic [7:0] id);
      @(negedge clk);
      va = a; va_is_write = w; cur_asid = id;
      #1;
   endtask

   // slot patterns
   function automatic logic [18:0] tag_of(input int i);
      return 19'(32'h1000 + i * 37);
   endfunction
   function automatic logic [7:0] asid_of(input int i);
      return 8'(8'h10 + i);
   endfunction
   function automatic logic [31:0] lo_word(input logic [5:0] junk, input logic g, input logic v,
                                           input logic d, input logic [2:0] c, input logic [19:0] p);
      return {junk, p, c, d, v, g};
   endfunction
   function automatic logic g_of(input int i, input int h);
      logic [3:0] b = 4'(i);
      return (h == 0) ? b[0] : b[1];
   endfunction
   function automatic logic v_of(input int i, input int h);
      return (h == 0) ? ((i % 5) != 2) : ((i % 7) != 1);
   endfunction
   function automatic logic d_of(input int i, input int h);
      logic [3:0] b = 4'(i);
      return (h == 0) ? b[1] : b[2];
   endfunction
   function automatic logic [2:0] c_of(input int i, input int h);
      logic [3:0] b = 4'(i);
      return (h == 0) ? b[2:0] : ~b[2:0];
   endfunction
   function automatic logic [19:0] p_of(input int i, input int h);
      return (h == 0) ? 20'(32'h100 + i * 2) : 20'(32'hABC00 + i);
   endfunction

   task automatic summary;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         nfail++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      logic [3:0] prev, r;
      logic       glob, vh, dh, match;
      logic [1:0] ef;
      logic [31:0] a;

      // R11 reset state
      repeat (3) @(negedge clk);
      chk("R11 random at reset", 64'(random_q), 64'd15);
      chk("R11 index at reset", 64'(index_q), 64'd0);
      chk("R11 wired at reset", 64'(wired_q), 64'd0);
      chk("R11 hi at reset", 64'(hi_q), 64'd0);
      rst_n = 1'b1;

      // R10 sequence with lower bound 0
      prev = 4'd15;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         r = random_q;
         chk("R10 countdown", 64'(r), 64'((prev == 4'd0) ? 4'd15 : prev - 4'd1));
         prev = r;
      end

      xl(32'h0000_0000, 1'b0, 8'h00);
      chk("R11 cleared slot gives invalid", 64'(fault), 64'd2);
      xl(32'h1234_5000, 1'b0, 8'h00);
      chk("R4 miss", 64'(fault), 64'd1);
      chk("R7 no perm on fault", 64'({perm_rd, perm_wr}), 64'd0);

      // R1 fill every slot by index
      for (int i = 0; i < 16; i++) begin
         stage(3'd0, {tag_of(i), 5'b10101, asid_of(i)});
         stage(3'd1, lo_word(6'b101101, g_of(i,0), v_of(i,0), d_of(i,0), c_of(i,0), p_of(i,0)));
         stage(3'd2, lo_word(6'b110011, g_of(i,1), v_of(i,1), d_of(i,1), c_of(i,1), p_of(i,1)));
         stage(3'd3, 32'(i));
         if (i == 0) begin
            chk("R12 hi select", 64'(hi_q), 64'({tag_of(0), 5'b10101, asid_of(0)}));
            chk("R12 lo0 select", 64'(lo0_q),
                64'(lo_word(6'b101101, g_of(0,0), v_of(0,0), d_of(0,0), c_of(0,0), p_of(0,0))));
            chk("R12 lo1 select", 64'(lo1_q),
                64'(lo_word(6'b110011, g_of(0,1), v_of(0,1), d_of(0,1), c_of(0,1), p_of(0,1))));
            chk("R12 index select", 64'(index_q), 64'd0);
         end
         do_op(2'd0);
      end

      // R3 R5 R6 R7 translation sweep
      for (int i = 0; i < 16; i++) begin
         for (int h = 0; h < 2; h++) begin
            for (int w = 0; w < 2; w++) begin
               for (int m = 0; m < 2; m++) begin
                  glob  = g_of(i,0) & g_of(i,1);
                  match = (m == 1) || glob;
                  vh = v_of(i,h);
                  dh = d_of(i,h);
                  if (!match)              ef = 2'd1;
                  else if (!vh)            ef = 2'd2;
                  else if ((w == 1) && !dh) ef = 2'd3;
                  else                     ef = 2'd0;
                  a = {tag_of(i), 1'(h), 12'(12'h5A0 + i)};
                  xl(a, 1'(w), (m == 1) ? asid_of(i) : 8'hEE);
                  chk("R5 R6 R3 fault code", 64'(fault), 64'(ef));
                  if (ef == 2'd0)
                     chk("R7 physical address", 64'(pa), 64'({p_of(i,h), a[11:0]}));
                  chk("R7 permissions", 64'({perm_rd, perm_wr}),
                      64'({ef == 2'd0, (ef == 2'd0) && dh}));
               end
            end
         end
      end

      // R8 read back every slot
      for (int i = 0; i < 16; i++) begin
         stage(3'd3, 32'(i));
         do_op(2'd2);
         glob = g_of(i,0) & g_of(i,1);
         chk("R8 hi readback", 64'(hi_q), 64'({tag_of(i), 5'b00000, asid_of(i)}));
         chk("R8 R3 lo0 readback", 64'(lo0_q),
             64'(lo_word(6'b0, glob, v_of(i,0), d_of(i,0), c_of(i,0), p_of(i,0))));
         chk("R8 R3 lo1 readback", 64'(lo1_q),
             64'(lo_word(6'b0, glob, v_of(i,1), d_of(i,1), c_of(i,1), p_of(i,1))));
      end

      // R9 probe
      stage(3'd0, {tag_of(7), 5'b00110, asid_of(7)});
      do_op(2'd3);
      chk("R9 probe hit", 64'(index_q), 64'd7);
      stage(3'd0, {tag_of(3), 5'b0, 8'hEE});
      do_op(2'd3);
      chk("R9 probe global hit", 64'(index_q), 64'd3);
      stage(3'd0, {tag_of(6), 5'b0, 8'hEE});
      do_op(2'd3);
      chk("R9 probe foreign id miss", 64'(index_q), 64'h8000_0000);
      stage(3'd0, {19'h7FFFF, 5'b0, 8'h10});
      do_op(2'd3);
      chk("R9 probe tag miss", 64'(index_q), 64'h8000_0000);

      // R3 duplicate tag in slot 9: slot 2 must win (its even half is invalid)
      stage(3'd0, {tag_of(2), 5'b0, asid_of(2)});
      stage(3'd1, lo_word(6'b0, 1'b0, 1'b1, 1'b1, 3'd0, 20'hDDDDD));
      stage(3'd2, lo_word(6'b0, 1'b0, 1'b1, 1'b1, 3'd0, 20'hDDDDE));
      stage(3'd3, 32'd9);
      do_op(2'd0);
      xl({tag_of(2), 1'b0, 12'h010}, 1'b0, asid_of(2));
      chk("R3 lowest slot wins", 64'(fault), 64'd2);
      do_op(2'd3);
      chk("R3 R9 probe lowest slot", 64'(index_q), 64'd2);

      // R12 op wins over staging write in the same cycle
      stage(3'd3, 32'd4);
      @(negedge clk);
      op_kind = 2'd2; op_go = 1'b1;
      stg_sel = 3'd0; stg_wdata = 32'hFFFF_FFFF; stg_we = 1'b1;
      @(negedge clk);
      op_go = 1'b0; stg_we = 1'b0;
      chk("R12 staging write dropped during op", 64'(hi_q), 64'({tag_of(4), 5'b0, asid_of(4)}));

      // R1 index masking: 0x35 lands in slot 5
      stage(3'd0, {19'h5EEDC, 5'b0, 8'h33});
      stage(3'd1, lo_word(6'b0, 1'b0, 1'b1, 1'b0, 3'd1, 20'h0F0F0));
      stage(3'd2, lo_word(6'b0, 1'b0, 1'b1, 1'b1, 3'd2, 20'h77777));
      stage(3'd3, 32'h0000_0035);
      do_op(2'd0);
      xl({19'h5EEDC, 1'b1, 12'hABC}, 1'b1, 8'h33);
      chk("R1 masked slot translate", 64'({fault, pa}), 64'({2'd0, 20'h77777, 12'hABC}));
      xl({19'h5EEDC, 1'b0, 12'hABC}, 1'b1, 8'h33);
      chk("R6 clean even half write", 64'(fault), 64'd3);
      xl({tag_of(5), 1'b0, 12'h000}, 1'b0, asid_of(5));
      chk("R1 old slot 5 replaced", 64'(fault), 64'd1);
      stage(3'd3, 32'd5);
      do_op(2'd2);
      chk("R1 readback slot 5", 64'(hi_q), 64'({19'h5EEDC, 5'b0, 8'h33}));

      // R10 with lower bound 12
      stage(3'd4, 32'd12);
      chk("R12 wired select", 64'(wired_q), 64'd12);
      prev = random_q;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         r = random_q;
         chk("R10 bounded countdown", 64'(r), 64'((prev <= 4'd12) ? 4'd15 : prev - 4'd1));
         prev = r;
      end

      // R2 replacement write
      stage(3'd0, {19'h7ABCD, 5'b0, 8'h42});
      stage(3'd1, lo_word(6'b0, 1'b0, 1'b1, 1'b1, 3'd0, 20'h12345));
      stage(3'd2, lo_word(6'b0, 1'b0, 1'b0, 1'b0, 3'd0, 20'h0));
      @(negedge clk);
      r = random_q;
      op_kind = 2'd1; op_go = 1'b1;
      @(negedge clk);
      op_go = 1'b0;
      xl({19'h7ABCD, 1'b0, 12'h0FF}, 1'b1, 8'h42);
      chk("R2 replacement translate", 64'({fault, pa}), 64'({2'd0, 32'h1234_50FF}));
      xl({19'h7ABCD, 1'b1, 12'h0FF}, 1'b0, 8'h42);
      chk("R5 odd half invalid", 64'(fault), 64'd2);
      stage(3'd3, 32'(r));
      do_op(2'd2);
      chk("R2 replacement slot", 64'(hi_q), 64'({19'h7ABCD, 5'b0, 8'h42}));

      done = 1'b1;
      summary();
      $finish;
   end
endmodule